// File: doc/BRIEF.md
# Fully Decoded Memory-Map Selector

This block turns a 16-bit processor address into the active-low chip selects of a small single-board computer. The top three address bits pick one of eight 8K blocks. Bits 9..7 pick one of eight 128-byte sub-blocks. The sub-block decoder is gated by bits 12..10 being zero, so the sub-block pattern repeats at the base of every 8K block. The block and sub-block selects are combined into selects for the on-board RAMs, the boot and expansion ROMs, the timer/port device and two off-board peripheral windows.

The block also controls the direction of the data buffers that join the on-board bus to the system bus. The buffers are turned inward only for a qualified read of an address that nothing on the board answers. Any other access leaves them driving outward.

Three strap inputs set the configuration:
- one moves a RAM bank from low memory to just above the stack RAM;
- one turns off the internal RAM at the bottom of memory;
- one frees the lowest 8K for off-board use.

The straps are registered on the system clock. All device selects and the inward buffer direction are qualified by the E clock and a valid-memory-address input.

Top module: `mapsel_top`

## Requirements
- R1: `blockSelN[i]` is low exactly when address bits 15..13 equal i. Exactly one of the eight bits is low for every address.
- R2: `subSelN[j]` is low exactly when address bits 12..10 are all zero and bits 9..7 equal j. When any of bits 12..10 is set, all eight bits are high.
- R3: `io1SelN` is low for $8000–$807F and `io2SelN` is low for $8080–$80FF. `timerSelN` is low for $8080–$808F, so it always overlaps `io2SelN`.
- R4: `bootRomSelN` is low for $F800–$FFFF. `extRomSelN` is low for $F000–$F7FF.
- R5: `stackRamSelN` is low for $8100–$817F.
- R6: `relocRamSelN` is low for $0080–$00FF while the registered relocation strap is 0, and for $8180–$81FF while it is 1. It is never low in both ranges under one setting.
- R7: `intRamSelN` is low for $0000–$007F unless the registered RAM-off strap is 1, in which case it stays high.
- R8: every device select (R3–R7) stays high unless both `eClk` and `vma` are high.
- R9: `bufToBus` (1 = buffers point outward) is 0 only when `eClk`, `vma` and `rnw` are all 1 and the address is not on-board. On-board means any of these: a device select other than `io1SelN`/`io2SelN` is active, or the address is in $0000–$1FFF while the low-free strap is 0.
- R10: with the registered low-free strap at 1, addresses in $0000–$1FFF that hit no enabled device give `bufToBus` = 0 on a qualified read.
- R11: the three straps are sampled on the rising edge of `clk` and act from the next edge on. While `rstN` is low the registered straps are all 0.
- R12: for any address and strap setting, at most one device select is low, except that `io2SelN` and `timerSelN` are low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the strap registers |
| rstN | input | 1 | Active-low asynchronous reset |
| addr | input | 16 | Processor address bus |
| rnw | input | 1 | 1 = read cycle, 0 = write cycle |
| eClk | input | 1 | Bus E clock; selects are valid only while high |
| vma | input | 1 | Valid memory address qualifier |
| relocStrap | input | 1 | 1 moves the relocatable RAM to $8180–$81FF |
| ramOffStrap | input | 1 | 1 disables the internal RAM select |
| lowFreeStrap | input | 1 | 1 releases $0000–$1FFF to off-board use |
| blockSelN | output | 8 | Active-low 8K block selects |
| subSelN | output | 8 | Active-low 128-byte sub-block selects |
| intRamSelN | output | 1 | Internal RAM select, $0000–$007F |
| relocRamSelN | output | 1 | Relocatable RAM select |
| stackRamSelN | output | 1 | Stack RAM select, $8100–$817F |
| io1SelN | output | 1 | Off-board peripheral window 1 |
| io2SelN | output | 1 | Off-board peripheral window 2 |
| timerSelN | output | 1 | Timer/port device select |
| extRomSelN | output | 1 | Expansion ROM select |
| bootRomSelN | output | 1 | Boot ROM select |
| bufToBus | output | 1 | Data buffer direction, 1 = outward |

## Verification
A short vector table probes the edges of every device window under chosen strap settings. It tells apart neighbouring windows that differ in a single address bit: $807F/$8080, $808F/$8090 and $F7FF/$F800. An exhaustive sweep of all 65536 addresses under each of the eight strap settings is compared against range-based expectations. The sweep separates the A12..A10 gating of the sub-block decoder from a plain 3-to-8 decode, and it shows the relocated bank moving rather than duplicating. Directed cases drop `eClk`, `vma` or `rnw` one at a time to show each qualifier's own effect on the selects and on the buffer direction. A further case changes a strap mid-cycle to show the one-edge latency of R11 and its reset default.

// File: rtl/mapsel_pkg.sv
package mapsel_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic cycleOk;
    logic relocHigh;
    logic intRamOff;
    logic lowFree;
  } mapStrobe_t;

  // device selects, one bit each
  typedef struct packed {
    logic intRam;
    logic relocRam;
    logic stackRam;
    logic io1;
    logic io2;
    logic timerPort;
    logic extRom;
    logic bootRom;
  } devSel_t;

  // 8K block indices that host devices
  localparam int LOW_BLOCK = 0;
  localparam int IO_BLOCK  = 4;
  localparam int ROM_BLOCK = 7;

  // sub-block indices inside those blocks
  localparam int SUB_INTRAM   = 0;
  localparam int SUB_RELOC_LO = 1;
  localparam int SUB_IO1      = 0;
  localparam int SUB_IO2      = 1;
  localparam int SUB_STACK    = 2;
  localparam int SUB_RELOC_HI = 3;

endpackage

// File: rtl/mapsel_lowdec.sv
module mapsel_lowdec #(
  parameter int IN_W = 3,
  localparam int OUT_N = 1 << IN_W
) (
  input  logic            en,
  input  logic [IN_W-1:0] sel,
  output logic [OUT_N-1:0] outN
);

  for (genvar i = 0; i < OUT_N; i++) begin : g_line
    assign outN[i] = ~(en && (sel == IN_W'(i)));
  end

endmodule

// File: rtl/mapsel_ctrl.sv
module mapsel_ctrl
  import mapsel_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       eClk,
  input  logic       vma,
  input  logic       relocStrap,
  input  logic       ramOffStrap,
  input  logic       lowFreeStrap,
  output mapStrobe_t strobe
);

  logic relocQ, ramOffQ, lowFreeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      relocQ   <= 1'b0;
      ramOffQ  <= 1'b0;
      lowFreeQ <= 1'b0;
    end else begin
      relocQ   <= relocStrap;
      ramOffQ  <= ramOffStrap;
      lowFreeQ <= lowFreeStrap;
    end
  end

  always_comb begin
    strobe.cycleOk   = eClk & vma;
    strobe.relocHigh = relocQ;
    strobe.intRamOff = ramOffQ;
    strobe.lowFree   = lowFreeQ;
  end

  // R11
  strap_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (strobe.relocHigh == $past(relocStrap)) &&
                    (strobe.intRamOff == $past(ramOffStrap)) &&
                    (strobe.lowFree   == $past(lowFreeStrap)));

endmodule

// File: rtl/mapsel_datapath.sv
module mapsel_datapath
  import mapsel_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int BLOCK_W = 3,
  parameter int SUB_W   = 3,
  parameter int SUB_LSB = 7,
  parameter int PORT_W  = 4,
  localparam int TOP_LSB = ADDR_W - BLOCK_W,
  localparam int GATE_LO = SUB_LSB + SUB_W,
  localparam int GATE_HI = TOP_LSB - 1,
  localparam int NBLK    = 1 << BLOCK_W,
  localparam int NSUB    = 1 << SUB_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rnw,
  input  mapStrobe_t        strobe,
  output logic [NBLK-1:0]   blockSelN,
  output logic [NSUB-1:0]   subSelN,
  output devSel_t           devSelN,
  output logic              bufToBus
);

  logic            subEn;
  logic [NBLK-1:0] blk;
  logic [NSUB-1:0] sub;
  devSel_t         hit;
  logic            onBoard;
  logic            romTop;
  logic            unusedLowBits;

  assign unusedLowBits = ^addr[PORT_W-1:0];
  assign subEn = ~|addr[GATE_HI:GATE_LO];

  mapsel_lowdec #(.IN_W(BLOCK_W)) u_blockDec (
    .en  (1'b1),
    .sel (addr[ADDR_W-1:TOP_LSB]),
    .outN(blockSelN)
  );

  mapsel_lowdec #(.IN_W(SUB_W)) u_subDec (
    .en  (subEn),
    .sel (addr[GATE_LO-1:SUB_LSB]),
    .outN(subSelN)
  );

  assign blk = ~blockSelN;
  assign sub = ~subSelN;
  assign romTop = blk[ROM_BLOCK] & addr[TOP_LSB-1];

  always_comb begin
    hit.intRam    = blk[LOW_BLOCK] & sub[SUB_INTRAM] & ~strobe.intRamOff;
    hit.relocRam  = strobe.relocHigh ? (blk[IO_BLOCK] & sub[SUB_RELOC_HI])
                                     : (blk[LOW_BLOCK] & sub[SUB_RELOC_LO]);
    hit.stackRam  = blk[IO_BLOCK] & sub[SUB_STACK];
    hit.io1       = blk[IO_BLOCK] & sub[SUB_IO1];
    hit.io2       = blk[IO_BLOCK] & sub[SUB_IO2];
    hit.timerPort = blk[IO_BLOCK] & sub[SUB_IO2] & ~|addr[SUB_LSB-1:PORT_W];
    hit.extRom    = romTop & ~addr[TOP_LSB-2];
    hit.bootRom   = romTop & addr[TOP_LSB-2];
  end

  assign devSelN = ~(hit & {$bits(devSel_t){strobe.cycleOk}});

  assign onBoard = hit.intRam | hit.relocRam | hit.stackRam | hit.timerPort |
                   hit.extRom | hit.bootRom | (blk[LOW_BLOCK] & ~strobe.lowFree);

  assign bufToBus = ~(strobe.cycleOk & rnw & ~onBoard);

  // R1
  block_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~blockSelN) == 1);

  // R2
  sub_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|addr[GATE_HI:GATE_LO]) |-> (&subSelN));

  // R3
  timer_in_io2_chk: assert property (@(posedge clk) disable iff (!rstN)
    !devSelN.timerPort |-> !devSelN.io2);

  // R12
  dev_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones({~devSelN.intRam, ~devSelN.relocRam, ~devSelN.stackRam,
                ~devSelN.io1, ~devSelN.io2, ~devSelN.extRom,
                ~devSelN.bootRom}) <= 1);

  // R8
  dev_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.cycleOk |-> (&devSelN));

  // R6
  reloc_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    !devSelN.relocRam |-> (addr[ADDR_W-1] == strobe.relocHigh));

  // R9
  buf_onboard_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!devSelN.bootRom || !devSelN.stackRam || !devSelN.timerPort) |-> bufToBus);

endmodule

// File: rtl/mapsel_top.sv
module mapsel_top
  import mapsel_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int BLOCK_W = 3,
  parameter int SUB_W   = 3,
  parameter int SUB_LSB = 7,
  parameter int PORT_W  = 4,
  localparam int NBLK   = 1 << BLOCK_W,
  localparam int NSUB   = 1 << SUB_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rnw,
  input  logic              eClk,
  input  logic              vma,
  input  logic              relocStrap,
  input  logic              ramOffStrap,
  input  logic              lowFreeStrap,
  output logic [NBLK-1:0]   blockSelN,
  output logic [NSUB-1:0]   subSelN,
  output logic              intRamSelN,
  output logic              relocRamSelN,
  output logic              stackRamSelN,
  output logic              io1SelN,
  output logic              io2SelN,
  output logic              timerSelN,
  output logic              extRomSelN,
  output logic              bootRomSelN,
  output logic              bufToBus
);

  mapStrobe_t strobe;
  devSel_t    devSelN;

  mapsel_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .eClk        (eClk),
    .vma         (vma),
    .relocStrap  (relocStrap),
    .ramOffStrap (ramOffStrap),
    .lowFreeStrap(lowFreeStrap),
    .strobe      (strobe)
  );

  mapsel_datapath #(
    .ADDR_W (ADDR_W),
    .BLOCK_W(BLOCK_W),
    .SUB_W  (SUB_W),
    .SUB_LSB(SUB_LSB),
    .PORT_W (PORT_W)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .addr     (addr),
    .rnw      (rnw),
    .strobe   (strobe),
    .blockSelN(blockSelN),
    .subSelN  (subSelN),
    .devSelN  (devSelN),
    .bufToBus (bufToBus)
  );

  assign intRamSelN   = devSelN.intRam;
  assign relocRamSelN = devSelN.relocRam;
  assign stackRamSelN = devSelN.stackRam;
  assign io1SelN      = devSelN.io1;
  assign io2SelN      = devSelN.io2;
  assign timerSelN    = devSelN.timerPort;
  assign extRomSelN   = devSelN.extRom;
  assign bootRomSelN  = devSelN.bootRom;

  // R8
  qual_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!bootRomSelN || !io1SelN || !intRamSelN) |-> (eClk && vma));

endmodule

// File: tb/mapsel_top_tb.sv
module mapsel_top_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] addr = '0;
  logic        rnw = 1'b1, eClk = 1'b1, vma = 1'b1;
  logic        relocStrap = 1'b0, ramOffStrap = 1'b0, lowFreeStrap = 1'b0;
  logic [7:0]  blockSelN, subSelN;
  logic        intRamSelN, relocRamSelN, stackRamSelN, io1SelN, io2SelN;
  logic        timerSelN, extRomSelN, bootRomSelN, bufToBus;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  mapsel_top u_dut (
    .clk(clk), .rstN(rstN), .addr(addr), .rnw(rnw), .eClk(eClk), .vma(vma),
    .relocStrap(relocStrap), .ramOffStrap(ramOffStrap), .lowFreeStrap(lowFreeStrap),
    .blockSelN(blockSelN), .subSelN(subSelN), .intRamSelN(intRamSelN),
    .relocRamSelN(relocRamSelN), .stackRamSelN(stackRamSelN), .io1SelN(io1SelN),
    .io2SelN(io2SelN), .timerSelN(timerSelN), .extRomSelN(extRomSelN),
    .bootRomSelN(bootRomSelN), .bufToBus(bufToBus)
  );

  // active-high device mask: intRam,reloc,stack,io1,io2,timer,extRom,bootRom
  function automatic logic [7:0] devMask();
    return ~{intRamSelN, relocRamSelN, stackRamSelN, io1SelN,
             io2SelN, timerSelN, extRomSelN, bootRomSelN};
  endfunction

  // straps packed as {reloc, ramOff, lowFree}
  function automatic logic [7:0] refMask(input logic [15:0] a, input logic [2:0] s);
    logic [7:0] m;
    m[7] = (a <= 16'h007F) && !s[1];
    m[6] = s[2] ? (a >= 16'h8180 && a <= 16'h81FF) : (a >= 16'h0080 && a <= 16'h00FF);
    m[5] = (a >= 16'h8100 && a <= 16'h817F);
    m[4] = (a >= 16'h8000 && a <= 16'h807F);
    m[3] = (a >= 16'h8080 && a <= 16'h80FF);
    m[2] = (a >= 16'h8080 && a <= 16'h808F);
    m[1] = (a >= 16'hF000 && a <= 16'hF7FF);
    m[0] = (a >= 16'hF800);
    return m;
  endfunction

  function automatic logic refBuf(input logic [15:0] a, input logic [2:0] s, input logic rd);
    logic [7:0] m;
    logic on;
    m  = refMask(a, s);
    on = (|(m & 8'b1110_0111)) || (a < 16'h2000 && !s[0]);
    return !(rd && !on);
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic setStraps(input logic [2:0] s);
    @(negedge clk);
    {relocStrap, ramOffStrap, lowFreeStrap} = s;
    @(posedge clk);
    #2;
  endtask

  // {addr, straps{reloc,ramOff,lowFree}, mask, bufToBus} with rnw=1
  localparam int NVEC = 22;
  localparam logic [27:0] VEC [NVEC] = '{
    {16'h0000, 3'b000, 8'h80, 1'b1},
    {16'h0000, 3'b010, 8'h00, 1'b1},
    {16'h007F, 3'b001, 8'h80, 1'b1},
    {16'h0080, 3'b000, 8'h40, 1'b1},
    {16'h0080, 3'b100, 8'h00, 1'b1},
    {16'h8180, 3'b100, 8'h40, 1'b1},
    {16'h8180, 3'b000, 8'h00, 1'b0},
    {16'h8000, 3'b000, 8'h10, 1'b0},
    {16'h807F, 3'b000, 8'h10, 1'b0},
    {16'h8080, 3'b000, 8'h0C, 1'b1},
    {16'h808F, 3'b000, 8'h0C, 1'b1},
    {16'h8090, 3'b000, 8'h08, 1'b0},
    {16'h8100, 3'b000, 8'h20, 1'b1},
    {16'h817F, 3'b000, 8'h20, 1'b1},
    {16'hF000, 3'b000, 8'h02, 1'b1},
    {16'hF7FF, 3'b000, 8'h02, 1'b1},
    {16'hF800, 3'b000, 8'h01, 1'b1},
    {16'hFFFF, 3'b000, 8'h01, 1'b1},
    {16'h1FFF, 3'b001, 8'h00, 1'b0},
    {16'h1FFF, 3'b000, 8'h00, 1'b1},
    {16'h2080, 3'b000, 8'h00, 1'b0},
    {16'h8400, 3'b000, 8'h00, 1'b0}
  };

  initial begin : watchdog
    #4_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    // R11 reset state: straps held at 1 but registered value stays 0
    relocStrap = 1'b1;
    addr = 16'h0080;
    repeat (3) @(posedge clk);
    #2;
    chk(!relocRamSelN, "R11 reset default reloc low", relocRamSelN, 0);
    addr = 16'h0000;
    #1;
    chk(blockSelN == 8'hFE, "R1 reset block select", blockSelN, 8'hFE);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #2;
    addr = 16'h8180;
    #1;
    chk(!relocRamSelN, "R11 strap active after edge", relocRamSelN, 0);

    // R11 latency: change strap, no effect before edge
    @(negedge clk);
    relocStrap = 1'b0;
    #1;
    chk(!relocRamSelN, "R11 no effect before edge", relocRamSelN, 0);
    @(posedge clk);
    #2;
    chk(relocRamSelN, "R11 effect after edge", relocRamSelN, 1);

    // vector table: R3 R4 R5 R6 R7 R9 R10
    for (int i = 0; i < NVEC; i++) begin
      setStraps(VEC[i][11:9]);
      addr = VEC[i][27:12];
      #1;
      chk(devMask() == VEC[i][8:1], "R3-7 table mask", {16'h0, addr, devMask()},
          {16'h0, addr, VEC[i][8:1]});
      chk(bufToBus == VEC[i][0], "R9 R10 table buffer", {addr, 15'h0, bufToBus},
          {addr, 15'h0, VEC[i][0]});
    end

    // R8: qualifiers
    setStraps(3'b000);
    addr = 16'hF900;
    eClk = 1'b0;
    #1;
    chk(devMask() == 8'h00, "R8 eClk low idles selects", devMask(), 8'h00);
    addr = 16'h9000;
    #1;
    chk(bufToBus == 1'b1, "R9 eClk low buffer outward", bufToBus, 1);
    eClk = 1'b1;
    vma = 1'b0;
    addr = 16'h8100;
    #1;
    chk(devMask() == 8'h00, "R8 vma low idles selects", devMask(), 8'h00);
    vma = 1'b1;
    #1;
    chk(devMask() == 8'h20, "R8 qualified stack", devMask(), 8'h20);

    // R9: write to off-board stays outward
    addr = 16'h9000;
    rnw = 1'b0;
    #1;
    chk(bufToBus == 1'b1, "R9 write off-board outward", bufToBus, 1);
    rnw = 1'b1;
    #1;
    chk(bufToBus == 1'b0, "R9 read off-board inward", bufToBus, 0);

    // R2: gated sub-block
    addr = 16'h6100;
    #1;
    chk(subSelN == 8'hFB, "R2 sub 2 in block 3", subSelN, 8'hFB);
    addr = 16'h6500;
    #1;
    chk(subSelN == 8'hFF, "R2 A10 gates sub decoder", subSelN, 8'hFF);

    // exhaustive sweep: R1 R2 R6 R7 R9 R10 R12
    for (int s = 0; s < 8; s++) begin
      logic bad;
      logic [15:0] badA;
      logic [31:0] badAct, badExp;
      setStraps(3'(s));
      bad = 1'b0;
      badA = '0;
      badAct = '0;
      badExp = '0;
      for (int a = 0; a < 65536; a++) begin
        logic [7:0] eb, es, em;
        logic ebuf;
        addr = 16'(a);
        #1;
        eb = ~(8'h01 << addr[15:13]);
        es = (addr[12:10] == 3'b000) ? ~(8'h01 << addr[9:7]) : 8'hFF;
        em = refMask(addr, 3'(s));
        ebuf = refBuf(addr, 3'(s), 1'b1);
        if (!bad && ({blockSelN, subSelN, devMask(), 7'h0, bufToBus} !=
                     {eb, es, em, 7'h0, ebuf})) begin
          bad = 1'b1;
          badA = addr;
          badAct = {blockSelN, subSelN, devMask(), 7'h0, bufToBus};
          badExp = {eb, es, em, 7'h0, ebuf};
        end
        if (!bad && ($countones(devMask() & 8'hFB) > 1)) begin
          bad = 1'b1;
          badA = addr;
          badAct = {24'h0, devMask()};
          badExp = {24'h0, em};
        end
      end
      if (bad) $display("sweep straps=%0d mismatch at addr %h", s, badA);
      chk(!bad, "R1 R2 R6 R7 R9 R10 R12 sweep", badAct, badExp);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule